// File: doc/BRIEF.md
# Pipeline Hazard Stall Controller

This block decides, each cycle, whether a five-stage in-order pipeline advances, freezes or discards work. It looks at the register numbers that the instruction in Decode reads, the kind of instruction sitting in Execute and the register it writes, a busy flag from a multi-cycle multiply/divide unit, and a branch-taken flag resolved in Execute. From these it drives the PC write enable, the enables of the Fetch/Decode and Decode/Execute pipeline registers, a bubble-insert control for Decode/Execute and a flush control for Fetch/Decode.

Three situations are handled with a fixed priority. A taken branch outranks everything: the PC loads the target, the fetched instruction is replaced by a no-op and the instruction in Decode is squashed. A multiply/divide in Execute freezes the front of the pipeline while it runs. A load followed by a dependent instruction costs one bubble. The controller keeps one bit of state, which records that the multiply/divide now in Execute has already been launched, so that the cycle in which busy falls releases the pipeline.

Execute class encoding on `x_class`: 0 = ALU/other, 1 = load, 2 = multiply/divide, 3 = branch. The five controls are listed below as the vector {pc_we, fd_en, fd_flush, dx_en, dx_bubble}.

Top module: `hzd_stall_ctrl`

## Requirements
- R1: With no taken branch, busy low and Execute class 0 or 3, the outputs are {1,1,0,1,0}: everything advances.
- R2: When Execute class is 1 and its destination equals a source register that Decode uses (its bit in `d_src_used` is 1) and that is not 0, with no taken branch and busy low, the outputs are {0,0,0,1,1}: PC and Fetch/Decode hold and one bubble enters Decode/Execute.
- R3: A load whose destination matches only a source of value 0, or only a source whose used bit is 0, causes no stall: the outputs are {1,1,0,1,0}.
- R4: When a multiply/divide (class 2) is in Execute and no launch is recorded, the outputs are {0,0,0,0,0} and a launch is recorded at the next clock.
- R5: With a launch recorded and class 2 in Execute, the pipeline stays frozen while busy is 1; in the first cycle busy is 0 the outputs are {1,1,0,1,0} and the launch record clears at the next clock.
- R6: Busy at 1 freezes the pipeline ({0,0,0,0,0}) whatever the Execute class, unless a branch is taken.
- R7: A taken branch gives {1,1,1,1,1} regardless of every other input, and `fd_flush` is 1 only when a branch is taken.
- R8: While reset is asserted, and for the two clocks after its release, the launch record stays clear, so a multiply/divide in Execute keeps the pipeline frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| d_src_idx | input | NSRC*AW | Source register numbers of the Decode instruction, source 0 in the low bits |
| d_src_used | input | NSRC | One bit per source: 1 if the Decode instruction reads it |
| x_class | input | 2 | Execute-stage instruction class (0 ALU, 1 load, 2 mul/div, 3 branch) |
| x_dst | input | AW | Destination register of the Execute instruction |
| md_busy | input | 1 | Multiply/divide unit still working |
| br_taken | input | 1 | Branch in Execute resolved as taken |
| pc_we | output | 1 | PC write enable |
| fd_en | output | 1 | Fetch/Decode register enable |
| fd_flush | output | 1 | Replace the instruction entering Fetch/Decode with a no-op |
| dx_en | output | 1 | Decode/Execute register enable |
| dx_bubble | output | 1 | Load a no-op into Decode/Execute instead of the Decode instruction |

## Verification
The properties assume that a multiply/divide unit reports busy only while its own instruction occupies Execute, that a branch is taken only by a branch-class instruction, and that an instruction frozen in Execute is still presented there on the following cycle. The random stimulus follows a small model of the pipeline: while the bench model holds a launched multiply/divide, it keeps class 2 in Execute and randomises busy; otherwise it keeps busy low and raises the branch flag only with class 3. A few directed cycles break these rules on purpose to show the branch priority over a load hazard and over a fresh multiply/divide; the properties that depend on the assumptions stay consistent there.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef enum logic [1:0] {
    XC_ALU    = 2'd0,
    XC_LOAD   = 2'd1,
    XC_MULDIV = 2'd2,
    XC_BRANCH = 2'd3
  } xclass_e;

  typedef struct packed {
    logic pc_we;
    logic fd_en;
    logic fd_flush;
    logic dx_en;
    logic dx_bubble;
  } pipe_ctl_t;

  localparam pipe_ctl_t CTL_RUN    = '{pc_we: 1'b1, fd_en: 1'b1, fd_flush: 1'b0, dx_en: 1'b1, dx_bubble: 1'b0};
  localparam pipe_ctl_t CTL_FREEZE = '{pc_we: 1'b0, fd_en: 1'b0, fd_flush: 1'b0, dx_en: 1'b0, dx_bubble: 1'b0};
  localparam pipe_ctl_t CTL_BUBBLE = '{pc_we: 1'b0, fd_en: 1'b0, fd_flush: 1'b0, dx_en: 1'b1, dx_bubble: 1'b1};
  localparam pipe_ctl_t CTL_REDIR  = '{pc_we: 1'b1, fd_en: 1'b1, fd_flush: 1'b1, dx_en: 1'b1, dx_bubble: 1'b1};

endpackage

// File: rtl/hzd_rst_sync.sv
module hzd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/hzd_lu_detect.sv
module hzd_lu_detect #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic [NSRC*AW-1:0] src_idx,
  input  logic [NSRC-1:0]    src_used,
  input  logic               x_is_load,
  input  logic [AW-1:0]      x_dst,
  output logic               lu_hit
);

  logic [NSRC-1:0] per_src_hit;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic [AW-1:0] idx;
    logic          nonzero;
    assign idx     = src_idx[g*AW +: AW];
    assign nonzero = |idx;
    assign per_src_hit[g] = x_is_load & src_used[g] & nonzero & (idx == x_dst);
  end

  assign lu_hit = |per_src_hit;

endmodule

// File: rtl/hzd_md_track.sv
module hzd_md_track (
  input  logic clk,
  input  logic rst_n,
  input  logic x_is_md,
  input  logic md_busy,
  input  logic br_taken,
  output logic md_freeze
);

  logic launched_q;
  logic launched_d;
  logic launched_en;

  always_comb begin
    md_freeze   = md_busy | (x_is_md & ~launched_q);
    launched_d  = x_is_md & md_freeze & ~br_taken;
    launched_en = launched_q | x_is_md;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      launched_q <= 1'b0;
    end else if (launched_en) begin
      launched_q <= launched_d;
    end
  end

endmodule

// File: rtl/hzd_ctl_arb.sv
module hzd_ctl_arb
  import hzd_pkg::*;
(
  input  logic      br_taken,
  input  logic      md_freeze,
  input  logic      lu_hit,
  output pipe_ctl_t ctl
);

  always_comb begin
    if (br_taken) begin
      ctl = CTL_REDIR;
    end else if (md_freeze) begin
      ctl = CTL_FREEZE;
    end else if (lu_hit) begin
      ctl = CTL_BUBBLE;
    end else begin
      ctl = CTL_RUN;
    end
  end

endmodule

// File: rtl/hzd_stall_ctrl.sv
module hzd_stall_ctrl
  import hzd_pkg::*;
#(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC*AW-1:0] d_src_idx,
  input  logic [NSRC-1:0]    d_src_used,
  input  logic [1:0]         x_class,
  input  logic [AW-1:0]      x_dst,
  input  logic               md_busy,
  input  logic               br_taken,
  output logic               pc_we,
  output logic               fd_en,
  output logic               fd_flush,
  output logic               dx_en,
  output logic               dx_bubble
);

  localparam int RST_STAGES = 2;

  xclass_e   cls;
  logic      rst_sync_n;
  logic      x_is_load;
  logic      x_is_md;
  logic      lu_hit;
  logic      md_freeze;
  pipe_ctl_t ctl;

  assign cls       = xclass_e'(x_class);
  assign x_is_load = (cls == XC_LOAD);
  assign x_is_md   = (cls == XC_MULDIV);

  hzd_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hzd_lu_detect #(.AW(AW), .NSRC(NSRC)) u_lu_detect (
    .src_idx   (d_src_idx),
    .src_used  (d_src_used),
    .x_is_load (x_is_load),
    .x_dst     (x_dst),
    .lu_hit    (lu_hit)
  );

  hzd_md_track u_md_track (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .x_is_md   (x_is_md),
    .md_busy   (md_busy),
    .br_taken  (br_taken),
    .md_freeze (md_freeze)
  );

  hzd_ctl_arb u_ctl_arb (
    .br_taken  (br_taken),
    .md_freeze (md_freeze),
    .lu_hit    (lu_hit),
    .ctl       (ctl)
  );

  assign pc_we     = ctl.pc_we;
  assign fd_en     = ctl.fd_en;
  assign fd_flush  = ctl.fd_flush;
  assign dx_en     = ctl.dx_en;
  assign dx_bubble = ctl.dx_bubble;

endmodule

// File: rtl/hzd_stall_ctrl_chk.sv
module hzd_stall_ctrl_chk #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic [NSRC*AW-1:0] d_src_idx,
  input logic [NSRC-1:0]    d_src_used,
  input logic [1:0]         x_class,
  input logic [AW-1:0]      x_dst,
  input logic               md_busy,
  input logic               br_taken,
  input logic               pc_we,
  input logic               fd_en,
  input logic               fd_flush,
  input logic               dx_en,
  input logic               dx_bubble
);

  logic dep_any;

  always_comb begin
    dep_any = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (d_src_used[i] && (d_src_idx[i*AW +: AW] != '0) && (d_src_idx[i*AW +: AW] == x_dst)) begin
        dep_any = 1'b1;
      end
    end
  end

  AST_CLEAN_ADVANCE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((x_class == 2'd0 || x_class == 2'd3) && !md_busy && !br_taken)
      |-> (pc_we && fd_en && dx_en && !dx_bubble && !fd_flush)); // R1

  AST_LOAD_USE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (x_class == 2'd1 && dep_any && !md_busy && !br_taken)
      |-> (!pc_we && !fd_en && dx_en && dx_bubble && !fd_flush)); // R2

  AST_LOAD_NO_DEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (x_class == 2'd1 && !dep_any && !md_busy && !br_taken)
      |-> (pc_we && fd_en && !dx_bubble)); // R3

  AST_MD_LAUNCH_FREEZE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(x_class != 2'd2 || dx_en) && x_class == 2'd2 && !br_taken)
      |-> (!pc_we && !fd_en && !dx_en && !dx_bubble)); // R4

  AST_MD_RELEASE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(x_class == 2'd2 && !dx_en && !br_taken)
      && x_class == 2'd2 && !md_busy && !br_taken)
      |-> (pc_we && fd_en && dx_en && !dx_bubble)); // R5

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (md_busy && !br_taken) |-> (!pc_we && !fd_en && !dx_en && !dx_bubble)); // R6

  AST_BRANCH_WINS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    br_taken |-> (pc_we && fd_en && fd_flush && dx_en && dx_bubble)); // R7

  AST_FLUSH_NEEDS_BRANCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fd_flush |-> br_taken); // R7

  AST_BUBBLE_WITH_ENABLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dx_bubble |-> dx_en); // R2

endmodule

bind hzd_stall_ctrl hzd_stall_ctrl_chk #(.AW(AW), .NSRC(NSRC)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .d_src_idx  (d_src_idx),
  .d_src_used (d_src_used),
  .x_class    (x_class),
  .x_dst      (x_dst),
  .md_busy    (md_busy),
  .br_taken   (br_taken),
  .pc_we      (pc_we),
  .fd_en      (fd_en),
  .fd_flush   (fd_flush),
  .dx_en      (dx_en),
  .dx_bubble  (dx_bubble)
);

// File: tb/hzd_stall_ctrl_bench.sv
module hzd_stall_ctrl_bench;

  localparam int AW   = 5;
  localparam int NSRC = 2;

  logic               clk;
  logic               rst_n;
  logic [NSRC*AW-1:0] d_src_idx;
  logic [NSRC-1:0]    d_src_used;
  logic [1:0]         x_class;
  logic [AW-1:0]      x_dst;
  logic               md_busy;
  logic               br_taken;
  logic               pc_we, fd_en, fd_flush, dx_en, dx_bubble;

  integer checks = 0;
  integer errors = 0;
  bit     m_run  = 1'b0;
  bit     m_next = 1'b0;

  hzd_stall_ctrl #(.AW(AW), .NSRC(NSRC)) u_hzd_stall_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .d_src_idx  (d_src_idx),
    .d_src_used (d_src_used),
    .x_class    (x_class),
    .x_dst      (x_dst),
    .md_busy    (md_busy),
    .br_taken   (br_taken),
    .pc_we      (pc_we),
    .fd_en      (fd_en),
    .fd_flush   (fd_flush),
    .dx_en      (dx_en),
    .dx_bubble  (dx_bubble)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks = checks + 1;
    errors = errors + 1;
    $display("FAIL watchdog: run did not complete, got hung, expected finish");
    summary();
  end

  // advance to the next falling edge and take the model's state for this cycle
  task automatic tick();
    @(negedge clk);
    m_run = m_next;
  endtask

  task automatic set_in(input int s0, input int s1, input int used, input int cls,
                        input int dst, input bit busy, input bit br);
    d_src_idx  = {AW'(s1), AW'(s0)};
    d_src_used = NSRC'(used);
    x_class    = 2'(cls);
    x_dst      = AW'(dst);
    md_busy    = busy;
    br_taken   = br;
  endtask

  task automatic chk(input bit in_reset);
    bit       is_md, dep;
    bit [4:0] exp_v, act_v;
    string    tag;
    #1;
    is_md = (x_class == 2'd2);
    dep = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      int idx = int'(d_src_idx[i*AW +: AW]);
      if (d_src_used[i] && idx != 0 && idx == int'(x_dst)) dep = 1'b1;
    end
    if (br_taken) begin
      exp_v = 5'b11111; tag = "R7";
    end else if (md_busy) begin
      exp_v = 5'b00000; tag = "R6";
    end else if (is_md && !m_run) begin
      exp_v = 5'b00000; tag = in_reset ? "R8" : "R4";
    end else if (is_md) begin
      exp_v = 5'b11010; tag = "R5";
    end else if (x_class == 2'd1 && dep) begin
      exp_v = 5'b00011; tag = "R2";
    end else if (x_class == 2'd1) begin
      exp_v = 5'b11010; tag = "R3";
    end else begin
      exp_v = 5'b11010; tag = "R1";
    end
    if (is_md && m_run && md_busy && !br_taken) tag = "R5";
    m_next = !in_reset && is_md && !br_taken && (md_busy || !m_run);
    act_v = {pc_we, fd_en, fd_flush, dx_en, dx_bubble};
    checks = checks + 1;
    if (act_v !== exp_v) begin
      errors = errors + 1;
      $display("FAIL %s at %0t: {pc_we,fd_en,fd_flush,dx_en,dx_bubble} got %b expected %b",
               tag, $time, act_v, exp_v);
    end
  endtask

  task automatic step(input int s0, input int s1, input int used, input int cls,
                      input int dst, input bit busy, input bit br);
    tick();
    set_in(s0, s1, used, cls, dst, busy, br);
    chk(1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    set_in(0, 0, 0, 0, 0, 1'b0, 1'b0);
    // R8: mul/div held in Execute under reset keeps freezing
    for (int k = 0; k < 3; k++) begin
      tick();
      set_in(1, 2, 3, 2, 7, 1'b0, 1'b0);
      chk(1'b1);
    end
    tick();
    set_in(0, 0, 0, 0, 0, 1'b0, 1'b0);
    rst_n = 1'b1;
    chk(1'b1);
    for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, 1'b0, 1'b0);

    // R1 plain advance, ALU and branch-not-taken
    step(3, 4, 3, 0, 3, 1'b0, 1'b0);
    step(3, 4, 3, 3, 4, 1'b0, 1'b0);
    // R2 load-use on source 0 and on source 1
    step(3, 4, 3, 1, 3, 1'b0, 1'b0);
    step(3, 4, 3, 1, 4, 1'b0, 1'b0);
    // R3 zero register, unused field, no match
    step(0, 4, 3, 1, 0, 1'b0, 1'b0);
    step(6, 5, 1, 1, 5, 1'b0, 1'b0);
    step(6, 5, 2, 1, 6, 1'b0, 1'b0);
    step(6, 5, 3, 1, 9, 1'b0, 1'b0);
    // R7 branch overrides load-use and a fresh mul/div
    step(3, 4, 3, 1, 3, 1'b0, 1'b1);
    step(3, 4, 3, 2, 3, 1'b0, 1'b1);
    step(0, 0, 0, 0, 0, 1'b0, 1'b0);
    // R4/R5 multi-cycle mul/div
    step(1, 2, 3, 2, 8, 1'b0, 1'b0);
    step(1, 2, 3, 2, 8, 1'b1, 1'b0);
    step(1, 2, 3, 2, 8, 1'b1, 1'b0);
    step(1, 2, 3, 2, 8, 1'b1, 1'b0);
    step(1, 2, 3, 2, 8, 1'b0, 1'b0);
    step(8, 2, 3, 0, 1, 1'b0, 1'b0);
    // R5 one-cycle mul/div, then back-to-back
    step(1, 2, 3, 2, 8, 1'b0, 1'b0);
    step(1, 2, 3, 2, 8, 1'b0, 1'b0);
    step(1, 2, 3, 2, 9, 1'b0, 1'b0);
    step(1, 2, 3, 2, 9, 1'b0, 1'b0);
    // R6 busy alone
    step(1, 2, 3, 0, 9, 1'b1, 1'b0);
    step(0, 0, 0, 0, 0, 1'b0, 1'b0);

    // constrained random pipeline traffic
    for (int n = 0; n < 600; n++) begin
      int s0, s1, used, cls, dst;
      bit busy, br;
      tick();
      s0   = int'($urandom_range(0, 7));
      s1   = int'($urandom_range(0, 7));
      used = int'($urandom_range(0, 3));
      dst  = int'($urandom_range(0, 7));
      if (m_run) begin
        cls  = 2;
        busy = ($urandom_range(0, 9) < 7);
        br   = 1'b0;
      end else begin
        cls  = int'($urandom_range(0, 3));
        busy = 1'b0;
        br   = (cls == 3) && ($urandom_range(0, 1) == 1);
      end
      set_in(s0, s1, used, cls, dst, busy, br);
      chk(1'b0);
    end

    summary();
  end

endmodule